// File: doc/BRIEF.md
# Parallel Smart-Panel Write Engine

This block feeds a smart display panel that keeps its own frame memory over an 8080-style parallel bus. For every pixel word it takes from a ready/valid source, it drives an active-low chip select and an active-low write strobe, and holds the word on the data bus while chip select is low. Four phase lengths, each counted in clock cycles, shape the strobes. They come from one configuration word that also carries the interface enable.

Software starts an update with a trigger command. The update does not begin at once: it stays pending until the next rising edge of the panel's tearing-effect input. That edge launches a frame of width × height words and consumes the pending request. At the end of the frame a done-interrupt pending bit is set. With the interrupt enabled, the block stays in a triggering state from the accepted trigger until the frame completes. Any trigger seen in that state is dropped, because repeated triggers can reset the panel. With the interrupt disabled, the triggering state is never entered.

Top module: `panel_wr_bus`

## Requirements
- R1: After reset cs_n and wr_n are 1, pix_ready is 0, busy is 0 and irq is 0.
- R2: cfg_word fields are: bit 0 enable, bits 19:16 chip-select setup, bits 15:12 write setup, bits 11:8 write active, bits 7:4 write hold. While enable is 0, triggers and TE edges start no bus activity.
- R3: A trigger is accepted only when trig_ctl bit 0 (trigger mode) and bit 1 (trigger command) are both 1 at a clock edge. A command given without the mode bit is ignored.
- R4: An accepted trigger starts a frame only at the next TE rising edge, and only when no frame is running. That launch consumes the pending request, so a later TE edge starts nothing.
- R5: For each word, cs_n is low for css+wrs+(act+1)+hold cycles. wr_n falls after css+wrs cycles of cs_n low and stays low for act+1 cycles. wr_n is never low while cs_n is high.
- R6: pix_ready is 1 only while the block waits for a word, and never while cs_n is low. db holds the accepted word, unchanged, for as long as cs_n stays low.
- R7: A frame carries frame_w*frame_h words in source order. Its end sets the interrupt pending bit. irq equals pending AND irq_en.
- R8: With irq_en at 1, busy rises on an accepted trigger and holds until frame end. A trigger seen while busy is ignored.
- R9: With irq_en at 0, busy stays 0 and a trigger given during a running frame is accepted. It launches a new frame on a TE edge after the running one ends.
- R10: A one-cycle pulse on irq_clr clears the interrupt pending bit, unless a frame ends in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every phase length counts its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 20 | Enable and four phase lengths |
| trig_ctl | input | 2 | Bit 0 trigger mode, bit 1 trigger command |
| irq_en | input | 1 | Frame-done interrupt enable |
| irq_clr | input | 1 | Write-one clear of the interrupt pending bit |
| frame_w | input | 10 | Frame width in words |
| frame_h | input | 10 | Frame height in lines |
| te | input | 1 | Tearing-effect input from the panel |
| pix_valid | input | 1 | Pixel source has a word |
| pix_data | input | 16 | Pixel word |
| pix_ready | output | 1 | Block takes a word this cycle |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Panel write strobe, active low |
| db | output | 16 | Panel data bus |
| busy | output | 1 | Triggering state |
| irq | output | 1 | Frame-done interrupt |

## Verification
The hardest situation to reach is a trigger that lands in the middle of a running frame, because its outcome depends on irq_en. The stimulus waits until the bus monitor has counted the first word of a frame, then issues the trigger. After the frame ends it gives a fresh TE edge. With the interrupt enabled, no new word may appear. With it disabled, a full second frame must appear. A second TE edge after a completed frame is used to show that the pending request is consumed by its launch.

// File: rtl/panel_wr_pkg.sv
// Shared types for the parallel panel write engine.
// Assumes a 20-bit configuration word with the field layout given in the brief.
package panel_wr_pkg;
    localparam int PH_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE, PH_FETCH, PH_CSS, PH_WRS, PH_ACT, PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [PH_W-1:0] css;
        logic [PH_W-1:0] wrs;
        logic [PH_W-1:0] act;
        logic [PH_W-1:0] hold;
    } timing_t;

    // Split the configuration word into its phase lengths.
    function automatic timing_t decode_timing(input logic [19:0] w);
        timing_t t;
        t.css  = w[19:16];
        t.wrs  = w[15:12];
        t.act  = w[11:8];
        t.hold = w[7:4];
        return t;
    endfunction
endpackage

// File: rtl/panel_wr_trig.sv
// Trigger latch, TE edge gate and frame-done interrupt bit.
// Assumes te is already in the clk domain and frame_done is a one-cycle pulse.
module panel_wr_trig (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] trig_ctl,
    input  logic       irq_en,
    input  logic       irq_clr,
    input  logic       te,
    input  logic       seq_idle,
    input  logic       frame_done,
    output logic       launch,
    output logic       busy,
    output logic       irq_pend
);
    logic te_q;
    logic pending;
    logic accept;
    logic te_rise;

    assign te_rise = te & ~te_q;
    assign accept  = en & trig_ctl[0] & trig_ctl[1] & ~busy;
    assign launch  = pending & te_rise & seq_idle & en;

    // Remember te for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) te_q <= 1'b0;
        else        te_q <= te;
    end

    // Pending request: set by an accepted trigger, consumed by a launch.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending & ~launch) | accept;
    end

    // Triggering state: entered only with the interrupt enabled, left at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy <= 1'b0;
        else if (frame_done)       busy <= 1'b0;
        else if (accept && irq_en) busy <= 1'b1;
    end

    // Interrupt pending bit: set at frame end, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_pend <= 1'b0;
        else if (frame_done) irq_pend <= 1'b1;
        else if (irq_clr)    irq_pend <= 1'b0;
    end

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !frame_done |=> busy);
    // R9
    no_busy_wo_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en && !busy |=> !busy);
    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !frame_done |=> !irq_pend);
endmodule

// File: rtl/panel_wr_seq.sv
// Strobe sequencer: takes one word at a time and walks the phases chip-select
// setup, write setup, write active and write hold. Phases of length zero are
// skipped; write active always lasts act+1 cycles.
// Assumes launch arrives only while idle; timing and frame size are latched at launch.
module panel_wr_seq #(
    parameter int DW = 16,
    parameter int NW = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   launch,
    input  panel_wr_pkg::timing_t  tm,
    input  logic [NW-1:0]          words,
    input  logic                   pix_valid,
    input  logic [DW-1:0]          pix_data,
    output logic                   pix_ready,
    output logic                   cs_n,
    output logic                   wr_n,
    output logic [DW-1:0]          db,
    output logic                   idle,
    output logic                   done
);
    import panel_wr_pkg::*;

    phase_e          st;
    logic [PH_W-1:0] cnt;
    timing_t         tl;
    logic [NW-1:0]   left;
    logic [DW-1:0]   dq;
    phase_e          first_st;
    logic [PH_W-1:0] first_cnt;
    logic            last_word;

    assign last_word = (left == NW'(1));

    // Pick the first phase after a word is taken, skipping empty setups.
    always_comb begin
        if (tl.css != '0) begin
            first_st  = PH_CSS;
            first_cnt = tl.css - 1'b1;
        end else if (tl.wrs != '0) begin
            first_st  = PH_WRS;
            first_cnt = tl.wrs - 1'b1;
        end else begin
            first_st  = PH_ACT;
            first_cnt = tl.act;
        end
    end

    // Phase state machine with per-phase down counter and word countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= PH_IDLE;
            cnt  <= '0;
            tl   <= '0;
            left <= '0;
            dq   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                PH_IDLE: if (launch) begin
                    tl   <= tm;
                    left <= words;
                    if (words == '0) done <= 1'b1;
                    else             st   <= PH_FETCH;
                end
                PH_FETCH: if (pix_valid) begin
                    dq  <= pix_data;
                    st  <= first_st;
                    cnt <= first_cnt;
                end
                PH_CSS: begin
                    if (cnt != '0)         cnt <= cnt - 1'b1;
                    else if (tl.wrs != '0) begin st <= PH_WRS; cnt <= tl.wrs - 1'b1; end
                    else                   begin st <= PH_ACT; cnt <= tl.act; end
                end
                PH_WRS: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else           begin st <= PH_ACT; cnt <= tl.act; end
                end
                PH_ACT, PH_HOLD: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else if (st == PH_ACT && tl.hold != '0) begin
                        st  <= PH_HOLD;
                        cnt <= tl.hold - 1'b1;
                    end else begin
                        left <= left - 1'b1;
                        if (last_word) begin st <= PH_IDLE; done <= 1'b1; end
                        else           st <= PH_FETCH;
                    end
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    assign idle      = (st == PH_IDLE);
    assign pix_ready = (st == PH_FETCH);
    assign cs_n      = !(st inside {PH_CSS, PH_WRS, PH_ACT, PH_HOLD});
    assign wr_n      = (st != PH_ACT);
    assign db        = dq;

    // R5
    wr_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cs_n);
    // R6
    ready_off_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> cs_n);
    // R6
    db_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n && $past(!cs_n) |-> $stable(db));
endmodule

// File: rtl/panel_wr_bus.sv
// Top of the parallel panel write engine: joins the trigger latch and the
// strobe sequencer and forms the frame size and interrupt output.
// Assumes te and all inputs are synchronous to clk.
module panel_wr_bus #(
    parameter int DW = 16,
    parameter int WW = 10,
    parameter int HW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [19:0]   cfg_word,
    input  logic [1:0]    trig_ctl,
    input  logic          irq_en,
    input  logic          irq_clr,
    input  logic [WW-1:0] frame_w,
    input  logic [HW-1:0] frame_h,
    input  logic          te,
    input  logic          pix_valid,
    input  logic [DW-1:0] pix_data,
    output logic          pix_ready,
    output logic          cs_n,
    output logic          wr_n,
    output logic [DW-1:0] db,
    output logic          busy,
    output logic          irq
);
    import panel_wr_pkg::*;
    localparam int NW = WW + HW;

    logic          launch;
    logic          seq_idle;
    logic          frame_done;
    logic          irq_pend;
    logic [NW-1:0] words;
    timing_t       tm;

    assign words = NW'(frame_w) * NW'(frame_h);
    assign tm    = decode_timing(cfg_word);
    assign irq   = irq_pend & irq_en;

    panel_wr_trig trig_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_word[0]),
        .trig_ctl   (trig_ctl),
        .irq_en     (irq_en),
        .irq_clr    (irq_clr),
        .te         (te),
        .seq_idle   (seq_idle),
        .frame_done (frame_done),
        .launch     (launch),
        .busy       (busy),
        .irq_pend   (irq_pend)
    );

    panel_wr_seq #(.DW(DW), .NW(NW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .tm        (tm),
        .words     (words),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .pix_ready (pix_ready),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .db        (db),
        .idle      (seq_idle),
        .done      (frame_done)
    );

    // R4
    launch_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch && words != '0 |=> !seq_idle);
endmodule

// File: tb/panel_wr_bus_tb.sv
// Directed bench for panel_wr_bus: one task per scenario, each checks its results.
module panel_wr_bus_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cfg_word = '0;
    logic [1:0]  trig_ctl = '0;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic [9:0]  frame_w = '0;
    logic [9:0]  frame_h = '0;
    logic        te = 1'b0;
    logic        pix_valid = 1'b1;
    logic [15:0] pix_data = '0;
    logic        pix_ready, cs_n, wr_n, busy, irq;
    logic [15:0] db;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bus monitor state
    int mon_words = 0;
    int cs_len [64];
    int wr_len [64];
    int lead   [64];
    logic [15:0] dat [64];
    int cur_cs, cur_wr;
    bit in_word = 0;
    bit wr_seen = 0;
    int src_idx = 0;
    logic [15:0] src_base = '0;

    panel_wr_bus dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .trig_ctl(trig_ctl),
        .irq_en(irq_en), .irq_clr(irq_clr), .frame_w(frame_w), .frame_h(frame_h),
        .te(te), .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .cs_n(cs_n), .wr_n(wr_n), .db(db), .busy(busy), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Measure each word on the bus and advance the pixel source once a word is taken.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n) begin
                if (!in_word) begin
                    in_word = 1; cur_cs = 0; cur_wr = 0; wr_seen = 0;
                    src_idx = src_idx + 1;
                    pix_data = src_base + 16'(src_idx);
                end
                cur_cs = cur_cs + 1;
                if (!wr_n) begin
                    if (!wr_seen) begin
                        wr_seen = 1;
                        if (mon_words < 64) begin
                            lead[mon_words] = cur_cs - 1;
                            dat[mon_words]  = db;
                        end
                    end
                    cur_wr = cur_wr + 1;
                end
            end else if (in_word) begin
                if (mon_words < 64) begin
                    cs_len[mon_words] = cur_cs;
                    wr_len[mon_words] = cur_wr;
                end
                mon_words = mon_words + 1;
                in_word = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig(input logic [1:0] v);
        trig_ctl = v; cyc(1); trig_ctl = 2'b00;
    endtask

    task automatic pulse_te();
        te = 1'b1; cyc(2); te = 1'b0; cyc(1);
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0; cyc(1);
    endtask

    task automatic set_cfg(input int css, input int wrs, input int act,
                           input int hold, input bit en);
        cfg_word = {4'(css), 4'(wrs), 4'(act), 4'(hold), 3'b000, en};
    endtask

    task automatic restart_mon(input logic [15:0] base);
        mon_words = 0; src_idx = 0; src_base = base; pix_data = base;
    endtask

    task automatic wait_words(input int n);
        int t = 0;
        while (mon_words < n && t < 5000) begin cyc(1); t++; end
        cyc(3);
    endtask

    // Compare every recorded word against the programmed phases and source order.
    task automatic check_words(input int css, input int wrs, input int act,
                               input int hold, input int n, input logic [15:0] base);
        int bad_cs = -1, bad_wr = -1, bad_ld = -1, bad_d = -1;
        chk(mon_words == n, "R7", "word count", mon_words, n);
        for (int k = 0; k < n && k < 64; k++) begin
            if (bad_cs < 0 && cs_len[k] != css+wrs+act+1+hold) bad_cs = k;
            if (bad_wr < 0 && wr_len[k] != act+1) bad_wr = k;
            if (bad_ld < 0 && lead[k] != css+wrs) bad_ld = k;
            if (bad_d < 0 && dat[k] != base + 16'(k)) bad_d = k;
        end
        chk(bad_cs < 0, "R5", "cs_n low cycles", bad_cs < 0 ? 0 : cs_len[bad_cs],
            css+wrs+act+1+hold);
        chk(bad_wr < 0, "R5", "wr_n low cycles", bad_wr < 0 ? 0 : wr_len[bad_wr], act+1);
        chk(bad_ld < 0, "R5", "cs to wr lead", bad_ld < 0 ? 0 : lead[bad_ld], css+wrs);
        chk(bad_d < 0, "R6", "db word", bad_d < 0 ? 0 : int'(dat[bad_d]),
            bad_d < 0 ? 0 : int'(base) + bad_d);
    endtask

    task automatic t_reset();
        chk(cs_n == 1 && wr_n == 1, "R1", "strobes idle", {cs_n, wr_n}, 3);
        chk(pix_ready == 0, "R1", "pix_ready", pix_ready, 0);
        chk(busy == 0 && irq == 0, "R1", "busy/irq", {busy, irq}, 0);
    endtask

    task automatic t_disabled();
        restart_mon(16'h0100);
        set_cfg(1, 1, 1, 1, 0); frame_w = 2; frame_h = 1; irq_en = 1;
        pulse_trig(2'b11);
        chk(busy == 0, "R2", "busy with enable 0", busy, 0);
        pulse_te(); cyc(40);
        chk(mon_words == 0, "R2", "words with enable 0", mon_words, 0);
    endtask

    task automatic t_no_mode();
        restart_mon(16'h0200);
        set_cfg(1, 1, 1, 1, 1); frame_w = 2; frame_h = 1; irq_en = 1;
        pulse_trig(2'b10);
        chk(busy == 0, "R3", "busy after command without mode", busy, 0);
        pulse_te(); cyc(40);
        chk(mon_words == 0, "R3", "words after command without mode", mon_words, 0);
    endtask

    task automatic t_basic_frame();
        restart_mon(16'h1000);
        set_cfg(1, 2, 3, 1, 1); frame_w = 3; frame_h = 2; irq_en = 1;
        pulse_trig(2'b11);
        chk(busy == 1, "R8", "busy after trigger", busy, 1);
        cyc(10);
        chk(mon_words == 0 && cs_n == 1, "R4", "no start before TE", mon_words, 0);
        pulse_te();
        wait_words(6);
        check_words(1, 2, 3, 1, 6, 16'h1000);
        chk(irq == 1, "R7", "irq after frame", irq, 1);
        chk(busy == 0, "R8", "busy after frame", busy, 0);
        pulse_clr();
        chk(irq == 0, "R10", "irq after clear", irq, 0);
        pulse_te(); cyc(60);
        chk(mon_words == 6, "R4", "second TE starts nothing", mon_words, 6);
    endtask

    task automatic t_zero_phases();
        restart_mon(16'h2000);
        set_cfg(0, 0, 0, 0, 1); frame_w = 4; frame_h = 1; irq_en = 1;
        pulse_trig(2'b11); pulse_te();
        wait_words(4);
        check_words(0, 0, 0, 0, 4, 16'h2000);
        pulse_clr();
    endtask

    task automatic t_long_phases();
        restart_mon(16'h3000);
        set_cfg(15, 15, 15, 15, 1); frame_w = 1; frame_h = 2; irq_en = 1;
        pulse_trig(2'b11); pulse_te();
        wait_words(2);
        check_words(15, 15, 15, 15, 2, 16'h3000);
        pulse_clr();
    endtask

    task automatic t_retrigger_busy();
        restart_mon(16'h4000);
        set_cfg(2, 2, 2, 2, 1); frame_w = 4; frame_h = 1; irq_en = 1;
        pulse_trig(2'b11); pulse_te();
        wait_words(1);
        pulse_trig(2'b11);
        wait_words(4);
        chk(busy == 0, "R8", "busy after frame", busy, 0);
        pulse_clr();
        pulse_te(); cyc(100);
        chk(mon_words == 4, "R8", "trigger while busy ignored", mon_words, 4);
        chk(irq == 0, "R8", "no extra frame-done", irq, 0);
    endtask

    task automatic t_no_irq();
        restart_mon(16'h5000);
        set_cfg(1, 0, 1, 0, 1); frame_w = 3; frame_h = 1; irq_en = 0;
        pulse_trig(2'b11);
        chk(busy == 0, "R9", "busy with irq_en 0", busy, 0);
        pulse_te();
        wait_words(1);
        pulse_trig(2'b11);
        wait_words(3);
        chk(irq == 0, "R7", "irq masked", irq, 0);
        pulse_te();
        wait_words(6);
        chk(mon_words == 6, "R9", "trigger during frame accepted", mon_words, 6);
        irq_en = 1; cyc(1);
        chk(irq == 1, "R7", "pending shown once enabled", irq, 1);
        pulse_clr();
        chk(irq == 0, "R10", "irq after clear", irq, 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_disabled();
        t_no_mode();
        t_basic_frame();
        t_zero_phases();
        t_long_phases();
        t_retrigger_busy();
        t_no_irq();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule